// File: doc/BRIEF.md
# Fixed-Point to Mini-Float Normalizer

This block turns an unsigned fixed-point number into a compact 16-bit floating word. The input has `IN_W` bits, and the lowest `FRAC_W` of them lie below the binary point. By default that is 16 bits with 8 integer bits and 8 fraction bits. The output word keeps a pure fractional mantissa in its upper field and a signed power of two in its lower field. The value it stands for is `0.M × 2^E`, where the mantissa always begins with a 1 right after the point.

A one-cycle `start_i` pulse launches a conversion. The block loads the value and then moves it one place left per clock, lowering the exponent each time, until the leading 1 reaches the top bit. It then packs the word and raises `done_o` for one cycle. Bits beyond the mantissa width are cut off, not rounded. A zero input takes a short path and finishes at once. An exponent that does not fit the exponent field sets `ovf_o` and forces a saturated word.

Top module: `minifloat_normalizer`

## Requirements
- R1: The word has the mantissa field in bits [15:6] and the exponent field in bits [5:0]. The exponent field is a two's complement integer E, and the word stands for 0.M × 2^E with the point just before bit 15.
- R2: For a nonzero input whose leading 1 sits at input bit p, a conversion in range gives mantissa bit 15 = 1 and E = p + 1 − FRAC_W. With the default widths that is E = p − 7.
- R3: The mantissa holds the MANT_W input bits that start at the leading 1. Lower input bits are dropped by truncation, and if fewer bits are left the field is padded with zeros on the right.
- R4: A negative exponent is stored in two's complement. For example, input 0x0001 gives E = −7, which is stored as field 6'b111001, so the word is 0x8039.
- R5: When a start is taken with a zero input, `done_o` is high right after the sampling clock edge, with word 0x0000 and `ovf_o` = 0.
- R6: For a nonzero input with its leading 1 at bit p, `done_o` is first high after the (IN_W − p + 1)-th clock edge, counting the edge that samples `start_i` as the first.
- R7: Each conversion gives exactly one `done_o` pulse. `word_o` and `ovf_o` change only on the edge that raises `done_o` and hold their value until the next completion.
- R8: A `start_i` that arrives while a conversion is in progress is ignored. It does not change the result and does not cause another completion.
- R9: If E would be above 2^(EXP_W−1) − 1 (31), `ovf_o` = 1 and the word saturates to an all-ones mantissa with exponent field 6'b011111, which is 0xFFDF.
- R10: If E would be below −2^(EXP_W−1) (−32), `ovf_o` = 1 and the word is 0x0000.
- R11: While reset is asserted and just after it, `done_o` = 0, `ovf_o` = 0 and `word_o` = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a conversion of `data_i` when the block is idle |
| data_i | input | IN_W (16) | Unsigned fixed-point value, with FRAC_W fraction bits |
| word_o | output | MANT_W+EXP_W (16) | Packed word: mantissa in the upper field, exponent in the lower field |
| done_o | output | 1 | One-cycle pulse when a new `word_o` is valid |
| ovf_o | output | 1 | Exponent out of range for the current `word_o` |

## Verification
On every cycle the assertions check these properties:
- every in-range nonzero result has its mantissa MSB set;
- the word and the flag move only together with `done_o`;
- an overflowed word is one of the two saturation patterns;
- a start taken with a zero input completes on the very next cycle with a zero word.

The exact exponent and mantissa values, truncation, the per-input latency, and the ignoring of a start during a run are shown only by the bench's scenarios. These scenarios include a second, wider instance whose exponents can cross both field limits.

// File: rtl/minifloat_pkg.sv
package minifloat_pkg;

    // Controller phases of the normalizer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_NORM = 1'b1
    } norm_state_e;

endpackage

// File: rtl/mf_range_chk.sv
// Compares the running exponent with the limits of the exponent field.
module mf_range_chk #(
    parameter int CNT_W = 7,
    parameter int EXP_W = 6
) (
    input  logic signed [CNT_W-1:0] ex_i,
    output logic                    too_big_o,
    output logic                    too_small_o
);

    localparam logic signed [CNT_W-1:0] EMAX = CNT_W'((2 ** (EXP_W - 1)) - 1);
    localparam logic signed [CNT_W-1:0] EMIN = CNT_W'(-(2 ** (EXP_W - 1)));

    always_comb begin
        too_big_o   = (ex_i > EMAX);
        too_small_o = (ex_i < EMIN);
    end

endmodule

// File: rtl/mf_word_pack.sv
// Puts the mantissa and exponent fields into one word, applying saturation.
module mf_word_pack #(
    parameter int MANT_W = 10,
    parameter int EXP_W  = 6
) (
    input  logic [MANT_W-1:0]       mant_i,
    input  logic [EXP_W-1:0]        exp_i,
    input  logic                    too_big_i,
    input  logic                    too_small_i,
    output logic [MANT_W+EXP_W-1:0] word_o
);

    localparam int WORD_W = MANT_W + EXP_W;
    localparam logic [WORD_W-1:0] SAT_HI = {{MANT_W{1'b1}}, 1'b0, {(EXP_W-1){1'b1}}};

    always_comb begin
        if (too_big_i) begin
            word_o = SAT_HI;
        end else if (too_small_i) begin
            word_o = '0;
        end else begin
            word_o = {mant_i, exp_i};
        end
    end

endmodule

// File: rtl/minifloat_normalizer.sv
module minifloat_normalizer
    import minifloat_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 8,
    parameter int MANT_W = 10,
    parameter int EXP_W  = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [IN_W-1:0]         data_i,
    output logic [MANT_W+EXP_W-1:0] word_o,
    output logic                    done_o,
    output logic                    ovf_o
);

    localparam int WORD_W   = MANT_W + EXP_W;
    localparam int CNT_BASE = $clog2(IN_W + 1) + 2;
    localparam int CNT_W    = (CNT_BASE > EXP_W + 1) ? CNT_BASE : EXP_W + 1;
    localparam logic [CNT_W-1:0] EXP_INIT = CNT_W'(IN_W - FRAC_W);
    localparam logic [CNT_W-1:0] EXP_STEP = CNT_W'(1);

    typedef struct packed {
        norm_state_e       st;
        logic [IN_W-1:0]   sh;
        logic [CNT_W-1:0]  ex;
        logic [WORD_W-1:0] word;
        logic              done;
        logic              ovf;
    } norm_regs_t;

    norm_regs_t reg_d, reg_q;

    logic [MANT_W-1:0] mant_w;
    logic [WORD_W-1:0] packed_w;
    logic              too_big_w;
    logic              too_small_w;

    // Mantissa slice: truncate when the shifter is wider, pad when narrower.
    if (IN_W >= MANT_W) begin : g_trunc
        assign mant_w = reg_q.sh[IN_W-1 -: MANT_W];
    end else begin : g_pad
        assign mant_w = {reg_q.sh, {(MANT_W-IN_W){1'b0}}};
    end

    mf_range_chk #(
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) range_i (
        .ex_i        ($signed(reg_q.ex)),
        .too_big_o   (too_big_w),
        .too_small_o (too_small_w)
    );

    mf_word_pack #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) pack_i (
        .mant_i      (mant_w),
        .exp_i       (reg_q.ex[EXP_W-1:0]),
        .too_big_i   (too_big_w),
        .too_small_i (too_small_w),
        .word_o      (packed_w)
    );

    always_comb begin
        reg_d      = reg_q;
        reg_d.done = 1'b0;
        case (reg_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (data_i == '0) begin
                        reg_d.word = '0;
                        reg_d.ovf  = 1'b0;
                        reg_d.done = 1'b1;
                    end else begin
                        reg_d.sh = data_i;
                        reg_d.ex = EXP_INIT;
                        reg_d.st = ST_NORM;
                    end
                end
            end
            ST_NORM: begin
                if (reg_q.sh[IN_W-1]) begin
                    reg_d.word = packed_w;
                    reg_d.ovf  = too_big_w | too_small_w;
                    reg_d.done = 1'b1;
                    reg_d.st   = ST_IDLE;
                end else begin
                    reg_d.sh = reg_q.sh << 1;
                    reg_d.ex = reg_q.ex - EXP_STEP;
                end
            end
            default: reg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            reg_q    <= '0;
            reg_q.st <= ST_IDLE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign word_o = reg_q.word;
    assign done_o = reg_q.done;
    assign ovf_o  = reg_q.ovf;

endmodule

// File: rtl/mf_norm_chk.sv
module mf_norm_chk #(
    parameter int IN_W   = 16,
    parameter int MANT_W = 10,
    parameter int EXP_W  = 6
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic [IN_W-1:0]         data_i,
    input logic [MANT_W+EXP_W-1:0] word_o,
    input logic                    done_o,
    input logic                    ovf_o
);

    localparam int WORD_W = MANT_W + EXP_W;
    localparam logic [WORD_W-1:0] SAT_HI = {{MANT_W{1'b1}}, 1'b0, {(EXP_W-1){1'b1}}};

    // Independent view of whether a conversion is running.
    logic run_q;
    logic idle_now;
    assign idle_now = !run_q || done_o;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= 1'b0;
        end else if (start_i && idle_now && data_i != '0) begin
            run_q <= 1'b1;
        end else if (done_o) begin
            run_q <= 1'b0;
        end
    end

    // R2
    normalized_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !ovf_o && word_o != '0) |-> word_o[WORD_W-1]);

    // R5
    zero_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && idle_now && data_i == '0) |=> (done_o && word_o == '0 && !ovf_o));

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(word_o) && $stable(ovf_o)));

    // R9 R10
    sat_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (word_o == SAT_HI || word_o == '0));

endmodule

bind minifloat_normalizer mf_norm_chk #(
    .IN_W   (IN_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .data_i  (data_i),
    .word_o  (word_o),
    .done_o  (done_o),
    .ovf_o   (ovf_o)
);

// File: tb/minifloat_normalizer_tb_top.sv
`timescale 1ns/1ps
module minifloat_normalizer_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Default instance
    logic        start_a = 1'b0;
    logic [15:0] data_a  = '0;
    logic [15:0] word_a;
    logic        done_a, ovf_a;

    minifloat_normalizer dut_i (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start_a), .data_i (data_a),
        .word_o (word_a), .done_o (done_a), .ovf_o (ovf_a)
    );

    // Wide instance: exponents can leave the field on both sides
    logic        start_b = 1'b0;
    logic [71:0] data_b  = '0;
    logic [15:0] word_b;
    logic        done_b, ovf_b;

    minifloat_normalizer #(.IN_W(72), .FRAC_W(36)) dut_w_i (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start_b), .data_i (data_b),
        .word_o (word_b), .done_o (done_b), .ovf_o (ovf_b)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // {data, expected word, expected latency}
    localparam int NVEC = 8;
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h05C0, 16'hB803, 8'd7},   // 5.75 -> .10111 x 2^3
        {16'h02FA, 16'hBE82, 8'd8},   // 2.98 truncated input
        {16'hFFFF, 16'hFFC8, 8'd2},   // low bits dropped
        {16'h8001, 16'h8008, 8'd2},   // low bit dropped
        {16'h0001, 16'h8039, 8'd17},  // exponent -7
        {16'h0100, 16'h8001, 8'd9},   // 1.0
        {16'h0080, 16'h8000, 8'd10},  // 0.5
        {16'h0003, 16'hC03A, 8'd16}   // exponent -6
    };

    task automatic run_a(input logic [15:0] d, input logic [15:0] ew, input int elat, input string req);
        int lat;
        @(negedge clk); start_a = 1'b1; data_a = d;
        @(negedge clk); start_a = 1'b0; lat = 1;
        while (!done_a && lat < 200) begin @(negedge clk); lat++; end
        chk(word_a == ew, req, 72'(word_a), 72'(ew));
        chk(ovf_a == 1'b0, {req, " ovf"}, 72'(ovf_a), 72'(0));
        chk(lat == elat, "R6 latency", 72'(lat), 72'(elat));
    endtask

    task automatic run_b(input int p, input logic [15:0] ew, input bit eo, input string req);
        int lat;
        @(negedge clk); start_b = 1'b1; data_b = 72'(1) << p;
        @(negedge clk); start_b = 1'b0; lat = 1;
        while (!done_b && lat < 200) begin @(negedge clk); lat++; end
        chk(word_b == ew, req, 72'(word_b), 72'(ew));
        chk(ovf_b == eo, {req, " ovf"}, 72'(ovf_b), 72'(eo));
        chk(lat == 72 - p + 1, "R6 latency wide", 72'(lat), 72'(72 - p + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(done_a == 1'b0 && ovf_a == 1'b0 && word_a == '0, "R11 during reset", 72'(word_a), 72'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_a == 1'b0 && ovf_a == 1'b0 && word_a == '0, "R11 after reset", 72'(word_a), 72'(0));

        // R1 R2 R3 R4 R6 vector table
        for (int i = 0; i < NVEC; i++) begin
            run_a(VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:0]), "R1 R2 R3 R4 vector");
        end

        // R5 zero input
        run_a(16'h0000, 16'h0000, 1, "R5 zero");

        // R7 hold after completion
        run_a(16'h0100, 16'h8001, 9, "R7 setup");
        repeat (5) @(negedge clk);
        chk(done_a == 1'b0, "R7 single pulse", 72'(done_a), 72'(0));
        chk(word_a == 16'h8001, "R7 hold", 72'(word_a), 72'h8001);

        // R8 start ignored while busy
        begin
            int lat;
            int extra = 0;
            @(negedge clk); start_a = 1'b1; data_a = 16'h0001;
            @(negedge clk); start_a = 1'b0; lat = 1;
            repeat (3) begin @(negedge clk); lat++; end
            start_a = 1'b1; data_a = 16'hFFFF;
            @(negedge clk); start_a = 1'b0; lat++;
            while (!done_a && lat < 200) begin @(negedge clk); lat++; end
            chk(word_a == 16'h8039, "R8 result", 72'(word_a), 72'h8039);
            chk(lat == 17, "R8 latency", 72'(lat), 72'd17);
            repeat (20) begin @(negedge clk); if (done_a) extra++; end
            chk(extra == 0, "R8 no extra done", 72'(extra), 72'(0));
        end

        // Wide instance: exponent = p + 1 - 36
        run_b(35, 16'h8000, 1'b0, "R2 wide exp 0");
        run_b(66, 16'h801F, 1'b0, "R2 wide exp +31");
        run_b(3,  16'h8020, 1'b0, "R4 wide exp -32");
        run_b(67, 16'hFFDF, 1'b1, "R9 exp +32");
        run_b(71, 16'hFFDF, 1'b1, "R9 exp +36");
        run_b(2,  16'h0000, 1'b1, "R10 exp -33");
        run_b(0,  16'h0000, 1'b1, "R10 exp -35");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule